// File: doc/BRIEF.md
# Inverse Quadratic Power-Map Substitution on a 160-bit Vector

This block takes a 160-bit word and picks out thirteen bits from fixed, irregular positions in it. Those bits form one element of the binary field GF(2^13). The block replaces that element with its preimage under the permutation F(X) = X^129 + X^3 + X, which is a bijection of GF(2^13). It then puts the thirteen result bits back into the same positions. The other 147 bits leave the block unchanged. It sits in a decryption datapath between two linear mixing layers and does the one nonlinear inversion step that they need.

The block does not load its 8192-entry inverse table from outside. It builds the table itself after reset. A sweep visits every field element x, evaluates F(x) with a squaring unit and two digit-serial field multipliers, and stores x at address F(x). Until the sweep has written all 8192 entries, the input side reports not-ready. After that, the block accepts one word per cycle and returns each result exactly two cycles after it was accepted.

Top module: `dob_inv_subst`

## Requirements
- R1: After reset, `in_ready` is low until all 8192 table entries have been written, which takes at least 8192 cycles. From then on it stays high.
- R2: A word accepted on a rising edge (`in_valid` and `in_ready` both high) produces `out_valid` high after the second following rising edge, and not after the first.
- R3: The field word is assembled with field bit k-1 taken from vector index p-1, where p runs through the positions 1, 2, 3, 4, 5, 6, 11, 16, 21, 26, 31, 36, 41 for k = 1 to 13. Vector index 0 is `in_vec[0]`.
- R4: The output field word w satisfies F(w) = the input field word. F(X) = X^129 + X^3 + X, computed modulo x^13 + x^4 + x^3 + x + 1.
- R5: Field bit k-1 of w is written to the same vector index from which input field bit k-1 was taken.
- R6: The 147 vector bits outside the thirteen field positions appear on `out_vec` with their input values.
- R7: Words offered while `in_ready` is low are ignored and never produce `out_valid`.
- R8: Words offered on consecutive cycles are each accepted, and their results leave in order, one per cycle.
- R9: A field word of zero maps to zero, and a field word of one maps to one.
- R10: `out_valid` is low in any cycle that does not follow an accepted word by exactly two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; starts the table sweep again |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Table complete; inputs are accepted |
| in_vec | input | 160 | Input vector |
| out_valid | output | 1 | Result present for this cycle only |
| out_vec | output | 160 | Substituted vector |

## Verification
The assertions assume that `in_valid` and `in_vec` carry known values in every cycle after reset. They also assume that the consumer takes every result in the cycle it appears, because the output side has no way to hold data back. The bench drives both inputs from time zero on the falling edge. It keeps `in_valid` at a defined level throughout, and it reads each result in the cycle its latency predicts. The bench checks the inversion by applying its own independent forward map to the returned field word, and it compares every untouched bit position directly.

// File: rtl/dobsub_pkg.sv
package dobsub_pkg;

    localparam int FIELD_W = 13;
    localparam int VEC_W = 160;
    // low terms of x^13 + x^4 + x^3 + x + 1
    localparam logic [FIELD_W-1:0] FIELD_POLY = 13'h001B;
    // X^128 needs seven squarings
    localparam int POW_SQUARINGS = 7;
    localparam int TABLE_DEPTH = 2 ** FIELD_W;

    // vector index feeding field bit k
    function automatic int zpos(input int k);
        return (k < 6) ? k : 5 * k - 20;
    endfunction

    function automatic logic [FIELD_W-1:0] gf_mulx(input logic [FIELD_W-1:0] a);
        logic [FIELD_W-1:0] r;
        r = {a[FIELD_W-2:0], 1'b0};
        if (a[FIELD_W-1]) begin
            r = r ^ FIELD_POLY;
        end
        return r;
    endfunction

    function automatic logic [FIELD_W-1:0] gf_sq(input logic [FIELD_W-1:0] a);
        logic [FIELD_W-1:0] r;
        logic [FIELD_W-1:0] t;
        r = '0;
        t = {{(FIELD_W-1){1'b0}}, 1'b1};
        for (int i = 0; i < FIELD_W; i++) begin
            if (a[i]) begin
                r = r ^ t;
            end
            t = gf_mulx(gf_mulx(t));
        end
        return r;
    endfunction

    function automatic logic [FIELD_W-1:0] zgather(input logic [VEC_W-1:0] v);
        logic [FIELD_W-1:0] w;
        for (int k = 0; k < FIELD_W; k++) begin
            w[k] = v[zpos(k)];
        end
        return w;
    endfunction

    function automatic logic [VEC_W-1:0] zscatter(input logic [VEC_W-1:0] v,
                                                  input logic [FIELD_W-1:0] w);
        logic [VEC_W-1:0] r;
        r = v;
        for (int k = 0; k < FIELD_W; k++) begin
            r[zpos(k)] = w[k];
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] pass_mask();
        logic [VEC_W-1:0] r;
        r = '1;
        for (int k = 0; k < FIELD_W; k++) begin
            r[zpos(k)] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/dobsub_mul.sv
module dobsub_mul
    import dobsub_pkg::*;
#(
    parameter int D = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FIELD_W-1:0] a_i,
    input  logic [FIELD_W-1:0] b_i,
    output logic               done_o,
    output logic [FIELD_W-1:0] prod_o
);

    localparam int STEPS = (FIELD_W + D - 1) / D;
    localparam int PAD = STEPS * D;
    localparam int CW = $clog2(STEPS + 1);

    typedef struct packed {
        logic [FIELD_W-1:0] acc;
        logic [FIELD_W-1:0] a;
        logic [PAD-1:0]     b;
        logic [CW-1:0]      step;
        logic               run;
        logic               done;
    } mul_t;

    mul_t q, d;

    always_comb begin
        logic [FIELD_W-1:0] t;
        logic [FIELD_W-1:0] sh;
        logic [D-1:0]       digit;
        d = q;
        d.done = 1'b0;
        t = q.acc;
        sh = q.a;
        digit = q.b[PAD-1 -: D];
        if (start_i) begin
            d.a = a_i;
            d.b = PAD'(b_i);
            d.acc = '0;
            d.step = '0;
            d.run = 1'b1;
        end else if (q.run) begin
            // MSB-first: acc * x^D plus a times the current digit
            for (int j = 0; j < D; j++) begin
                t = gf_mulx(t);
            end
            for (int j = 0; j < D; j++) begin
                if (digit[j]) begin
                    t = t ^ sh;
                end
                sh = gf_mulx(sh);
            end
            d.acc = t;
            d.b = q.b << D;
            d.step = q.step + 1'b1;
            if (q.step == CW'(STEPS - 1)) begin
                d.run = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign prod_o = q.acc;

endmodule

// File: rtl/dobsub_table_gen.sv
module dobsub_table_gen
    import dobsub_pkg::*;
#(
    parameter int MUL_DIGIT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               wr_en,
    output logic [FIELD_W-1:0] wr_addr,
    output logic [FIELD_W-1:0] wr_data,
    output logic               ready_o
);

    localparam int SQ_CW = $clog2(POW_SQUARINGS + 1);
    localparam logic [FIELD_W-1:0] LAST_ELEM = FIELD_W'(TABLE_DEPTH - 1);
    localparam int N_MUL = 2;

    typedef enum logic [1:0] {ST_SQ, ST_GO, ST_WAIT, ST_DONE} gen_state_e;

    typedef struct packed {
        gen_state_e         state;
        logic [FIELD_W-1:0] elem;
        logic [FIELD_W-1:0] pow;
        logic [FIELD_W-1:0] x2;
        logic [SQ_CW-1:0]   sq_cnt;
        logic               ready;
    } gen_t;

    gen_t q, d;

    logic                mul_start;
    logic [FIELD_W-1:0]  mul_a [N_MUL];
    logic [FIELD_W-1:0]  mul_p [N_MUL];
    logic [N_MUL-1:0]    mul_done;

    // operand 0 ends as X^128, operand 1 as X^2; both multiplied by X
    assign mul_a[0] = q.pow;
    assign mul_a[1] = q.x2;

    for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        dobsub_mul #(.D(MUL_DIGIT)) u_mul (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (mul_start),
            .a_i     (mul_a[g]),
            .b_i     (q.elem),
            .done_o  (mul_done[g]),
            .prod_o  (mul_p[g])
        );
    end

    always_comb begin
        d = q;
        mul_start = 1'b0;
        wr_en = 1'b0;
        wr_addr = mul_p[0] ^ mul_p[1] ^ q.elem;
        wr_data = q.elem;
        case (q.state)
            ST_SQ: begin
                d.pow = gf_sq(q.pow);
                if (q.sq_cnt == '0) begin
                    d.x2 = gf_sq(q.pow);
                end
                d.sq_cnt = q.sq_cnt + 1'b1;
                if (q.sq_cnt == SQ_CW'(POW_SQUARINGS - 1)) begin
                    d.sq_cnt = '0;
                    d.state = ST_GO;
                end
            end
            ST_GO: begin
                mul_start = 1'b1;
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (&mul_done) begin
                    wr_en = 1'b1;
                    if (q.elem == LAST_ELEM) begin
                        d.state = ST_DONE;
                        d.ready = 1'b1;
                    end else begin
                        d.elem = q.elem + 1'b1;
                        d.pow = q.elem + 1'b1;
                        d.state = ST_SQ;
                    end
                end
            end
            default: begin
                d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_SQ, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ready_o = q.ready;

endmodule

// File: rtl/dobsub_ram.sv
module dobsub_ram #(
    parameter int AW = 13,
    parameter int DW = 13
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/dob_inv_subst.sv
module dob_inv_subst
    import dobsub_pkg::*;
#(
    parameter int MUL_DIGIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_vec,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);

    typedef struct packed {
        logic             s1_v;
        logic [VEC_W-1:0] s1_vec;
        logic             o_v;
        logic [VEC_W-1:0] o_vec;
    } pipe_t;

    pipe_t q, d;

    logic               tbl_ready;
    logic               tbl_we;
    logic [FIELD_W-1:0] tbl_waddr;
    logic [FIELD_W-1:0] tbl_wdata;
    logic [FIELD_W-1:0] rd_addr;
    logic [FIELD_W-1:0] rd_data;
    logic               accept;

    dobsub_table_gen #(.MUL_DIGIT(MUL_DIGIT)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_waddr),
        .wr_data (tbl_wdata),
        .ready_o (tbl_ready)
    );

    dobsub_ram #(.AW(FIELD_W), .DW(FIELD_W)) u_ram (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_addr (tbl_waddr),
        .wr_data (tbl_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign accept = in_valid && tbl_ready;
    assign rd_addr = zgather(in_vec);

    always_comb begin
        d = q;
        d.s1_v = accept;
        if (accept) begin
            d.s1_vec = in_vec;
        end
        d.o_v = q.s1_v;
        if (q.s1_v) begin
            d.o_vec = zscatter(q.s1_vec, rd_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready = tbl_ready;
    assign out_valid = q.o_v;
    assign out_vec = q.o_vec;

endmodule

// File: rtl/dob_inv_subst_chk.sv
module dob_inv_subst_chk
    import dobsub_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [VEC_W-1:0] in_vec,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec
);

    localparam logic [VEC_W-1:0] KEEP = pass_mask();

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_ready) |-> in_ready); // R1

    AST_TWO_CYCLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_ready, 2) |-> out_valid); // R2

    AST_NO_OUT_WHILE_BUILDING: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !out_valid); // R7

    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 2)); // R10

    AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_vec & KEEP) == ($past(in_vec, 2) & KEEP))); // R6

    AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (zgather($past(in_vec, 2)) == '0)) |-> (zgather(out_vec) == '0)); // R9

endmodule

bind dob_inv_subst dob_inv_subst_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/dob_inv_subst_tb.sv
module dob_inv_subst_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [159:0] in_vec = '0;
    logic         out_valid;
    logic [159:0] out_vec;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam int ZP [13] = '{0, 1, 2, 3, 4, 5, 10, 15, 20, 25, 30, 35, 40};

    always #4 clk = ~clk;

    dob_inv_subst u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    function automatic logic [12:0] bmul(input logic [12:0] a, input logic [12:0] b);
        logic [25:0] p;
        p = '0;
        for (int i = 0; i < 13; i++) if (b[i]) p = p ^ ({13'b0, a} << i);
        for (int i = 24; i >= 13; i--) if (p[i]) p = p ^ (26'h201B << (i - 13));
        return p[12:0];
    endfunction

    function automatic logic [12:0] bfwd(input logic [12:0] x);
        logic [12:0] p;
        p = x;
        for (int i = 0; i < 7; i++) p = bmul(p, p);
        return bmul(p, x) ^ bmul(bmul(x, x), x) ^ x;
    endfunction

    function automatic logic [12:0] bgather(input logic [159:0] v);
        logic [12:0] w;
        for (int k = 0; k < 13; k++) w[k] = v[ZP[k]];
        return w;
    endfunction

    function automatic logic [159:0] bmask();
        logic [159:0] m;
        m = '1;
        for (int k = 0; k < 13; k++) m[ZP[k]] = 1'b0;
        return m;
    endfunction

    function automatic logic [159:0] mkvec(input int s);
        logic [159:0] v;
        for (int i = 0; i < 5; i++) v[i*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(i) * 32'h7F4A7C15;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R4 R5 R6: field word inverts forward map, other bits kept
    task automatic verify_out(input logic [159:0] vin, input string tag);
        logic [12:0] w;
        w = bgather(out_vec);
        chk((out_vec & bmask()) == (vin & bmask()), {"R6 ", tag}, out_vec & bmask(), vin & bmask());
        chk(bfwd(w) == bgather(vin), {"R4 R5 ", tag}, 160'(bfwd(w)), 160'(bgather(vin)));
    endtask

    task automatic t_reset_and_build();
        int cyc;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1 reset ready", 160'(in_ready), 160'd0);
        chk(out_valid == 1'b0, "R10 reset valid", 160'(out_valid), 160'd0);
        rst_n = 1'b1;
        in_valid = 1'b1;
        in_vec = mkvec(7);
        cyc = 0;
        begin
            bit seen = 1'b0;
            // R7: offers during build must not produce results
            while (!in_ready && cyc < 170000) begin
                @(negedge clk);
                cyc++;
                if (out_valid) seen = 1'b1;
                if (cyc == 200) in_valid = 1'b0;
            end
            chk(!seen, "R7 ignored during build", 160'(seen), 160'd0);
        end
        chk(in_ready == 1'b1 && cyc >= 8192, "R1 ready after sweep", 160'(cyc), 160'd8192);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 no late result", 160'(out_valid), 160'd0);
    endtask

    task automatic t_single(input logic [159:0] v, input string tag);
        in_vec = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, {"R2 not after one edge ", tag}, 160'(out_valid), 160'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, {"R2 valid after two edges ", tag}, 160'(out_valid), 160'd1);
        verify_out(v, tag);
        @(negedge clk);
        chk(out_valid == 1'b0, {"R10 single pulse ", tag}, 160'(out_valid), 160'd0);
    endtask

    task automatic t_corners();
        logic [159:0] v;
        // R9: zero word, zero field bits
        t_single('0, "zero");
        chk(out_vec == '0, "R9 zero stays zero", out_vec, '0);
        // R9 R3: only field bit 0 (index 0) set, 1 maps to 1
        v = 160'd1;
        t_single(v, "one");
        chk(out_vec == v, "R9 R3 one stays one", out_vec, v);
        // R3 R5: field MSB is index 40
        v = '0;
        v[40] = 1'b1;
        t_single(v, "msb");
        // R9 R6: field bits one, all other bits set
        v = bmask();
        v[0] = 1'b1;
        t_single(v, "one with rest set");
        chk(out_vec == v, "R9 R6 one with rest set", out_vec, v);
        t_single(~160'd0, "all ones");
    endtask

    // R8: back-to-back stream, optional gaps
    task automatic t_stream(input int seed, input bit gaps);
        logic [159:0] sent [20];
        bit           sv   [20];
        for (int c = 0; c < 22; c++) begin
            if (c >= 2) begin
                chk(out_valid == sv[c-2], "R8 R10 stream valid", 160'(out_valid), 160'(sv[c-2]));
                if (sv[c-2]) verify_out(sent[c-2], "stream");
            end
            if (c < 20) begin
                sv[c] = gaps ? (c % 3 != 1) : 1'b1;
                sent[c] = mkvec(seed + c);
                in_vec = sent[c];
                in_valid = sv[c];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk(out_valid == 1'b0, "R10 idle after stream", 160'(out_valid), 160'd0);
    endtask

    initial begin
        t_reset_and_build();
        t_corners();
        t_stream(100, 1'b0);
        t_stream(500, 1'b1);
        t_stream(9000, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule